// File: doc/BRIEF.md
# Sector Write-Protection Resolver

This block decides, for one word address at a time, whether a program or erase aimed at that address may proceed. The address space is split into small boot sectors at one end and large sectors everywhere else. Sectors are gathered into protection groups, and each group has one persistent protect bit held in a register outside this block. The resolver maps the address to its group and combines that group's stored bit with two pin levels. One is the write-protect pin: low, high or the high accelerate voltage. The other is the reset pin: low, high or the high temporary-unprotect voltage.

Every output is registered behind a single clock stage. The block returns the resolved group index, a verification byte that shows the group's stored protect bit, and a level that says whether a write to the address is allowed. It also drives a flag telling the command logic that unlock-bypass mode is forced. A caller raises a request for one cycle per program or erase attempt and receives either a one-cycle start pulse or a one-cycle reject pulse. The detection of the high pin voltages happens elsewhere; this block sees only their 2-bit encodings.

Top module: `sect_prot_resolver`

## Requirements
- R1: While the synchronous active-high reset is sampled high, every output reads zero on the following cycle, whatever the other inputs are.
- R2: With bottom-boot selected, and with slot = address[20:15], group numbering runs in ascending address order. In slot 0, group = address[14:12], which gives eight 4-Kword groups numbered 0 to 7. Slots 1 to 3 form group 8. Any other slot below 63 maps to group 8 + slot/4. Slot 63 alone is group 24, so there are 25 groups in all.
- R3: With top-boot selected, the arrangement is mirrored. The group is 24 minus the bottom-boot group of the bitwise-inverted address, so the eight boot groups are 17 to 24 at the top of the space.
- R4: The verify byte is 0x01 when the resolved group's stored bit is set and 0x00 when it is clear, regardless of pin levels.
- R5: The two outermost boot groups are 0 and 1 in bottom-boot and 23 and 24 in top-boot. When the write-protect level is low (code 0), these two groups are treated as protected whatever their stored bits say, and the temporary-unprotect level does not release them.
- R6: With the write-protect level high (code 1, and code 3 is treated the same) and the reset level high (code 1, and code 3 is treated the same), every group, the outermost included, is protected exactly when its stored bit is set.
- R7: With the write-protect level at the accelerate voltage (code 2), every group is unprotected and the bypass-forced output is 1. At any other write-protect code the bypass-forced output is 0.
- R8: With the reset level at the unprotect voltage (code 2), every group is unprotected except as stated in R5. Once the reset level returns to high, each group whose stored bit is set is protected again from the next cycle, and the stored bits themselves are never altered.
- R9: The permit output is 1 when the reset level is not low (code 0) and the group is unprotected. A request yields exactly one of a start pulse (when permitted) or a reject pulse (when blocked), one cycle wide. No request, or a reset level of low, yields neither pulse.
- R10: All outputs reflect the inputs sampled at the previous rising clock edge, with one register stage and no combinational path to any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 21 | Word address of the access |
| top_boot_i | input | 1 | 1 selects top-boot arrangement, 0 bottom-boot |
| grp_prot_i | input | 25 | Persistent protect bit per group, bit n for group n |
| wp_lvl_i | input | 2 | Write-protect pin level: 0 low, 1 high, 2 accelerate, 3 as high |
| rst_lvl_i | input | 2 | Reset pin level: 0 low, 1 high, 2 unprotect, 3 as high |
| req_i | input | 1 | Program or erase attempt at addr_i this cycle |
| grp_o | output | 5 | Resolved group index |
| prot_code_o | output | 8 | Verify byte, 0x01 protected, 0x00 unprotected |
| permit_o | output | 1 | A write to the address is allowed |
| go_o | output | 1 | One-cycle start pulse for an accepted request |
| reject_o | output | 1 | One-cycle reject pulse for a blocked request |
| bypass_o | output | 1 | Unlock-bypass mode is forced |

## Verification
The bench builds the block with its default parameters: a 21-bit word address, 4-Kword boot sectors inside 32-Kword large slots, and groups of four slots. That yields 25 groups. With this size, directed sweeps can visit every boot sector and every large slot in both orientations. They therefore reach the short first large group, the lone last slot and both outermost boot groups at each end. Random phases then cross all sixteen pin-level code pairs with random stored patterns, and directed steps step the reset level into and out of the unprotect voltage at a fixed address to watch protection come back.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // Encoded pin level as delivered by the external voltage detectors.
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_HV   = 2'd2,
    LVL_RSVD = 2'd3
  } lvl_e;

  // Number of protection groups: one per boot sector, one per aligned run
  // of large slots, plus one for the lone last slot.
  function automatic int grp_count(input int addr_w, input int large_w,
                                   input int boot_w, input int grp_sz);
    return (1 << (large_w - boot_w)) + (1 << (addr_w - large_w)) / grp_sz + 1;
  endfunction

endpackage

// File: rtl/wpr_group_map.sv
module wpr_group_map
  import wpr_pkg::*;
#(
  parameter int ADDR_W  = 21,
  parameter int LARGE_W = 15,
  parameter int BOOT_W  = 12,
  parameter int GRP_SZ  = 4,
  parameter int NGRP    = 25,
  parameter int GW      = 5
) (
  input  logic [ADDR_W-1:BOOT_W] hi_addr,
  input  logic                   top_boot,
  output logic [GW-1:0]          grp
);

  localparam int SLOT_W = ADDR_W - LARGE_W;
  localparam int BSEL_W = LARGE_W - BOOT_W;
  localparam int NBOOT  = 1 << BSEL_W;
  localparam int NSLOT  = 1 << SLOT_W;

  logic [ADDR_W-1:BOOT_W] m_addr;
  logic [SLOT_W-1:0]      slot;
  logic [BSEL_W-1:0]      bsel;
  logic [GW-1:0]          gm;

  // Top-boot is handled by mirroring the address and the group number, so
  // one bottom-boot decoder serves both arrangements.
  always_comb begin
    m_addr = top_boot ? ~hi_addr : hi_addr;
    slot   = m_addr[ADDR_W-1:LARGE_W];
    bsel   = m_addr[LARGE_W-1:BOOT_W];
    if (slot == '0)
      gm = GW'(bsel);
    else if (slot == SLOT_W'(NSLOT - 1))
      gm = GW'(NGRP - 1);
    else
      gm = GW'(NBOOT + int'(slot) / GRP_SZ);
    grp = top_boot ? (GW'(NGRP - 1) - gm) : gm;
  end

endmodule

// File: rtl/wpr_prot_eval.sv
module wpr_prot_eval
  import wpr_pkg::*;
#(
  parameter int NGRP = 25,
  parameter int GW   = 5
) (
  input  logic [GW-1:0]   grp,
  input  logic            top_boot,
  input  logic [NGRP-1:0] stored,
  input  lvl_e            wp,
  input  lvl_e            rl,
  output logic            eff_prot,
  output logic            stored_bit,
  output logic            outer
);

  logic [NGRP-1:0] eff_vec;
  logic [NGRP-1:0] outer_vec;

  // Effective protection is resolved for every group in parallel; the
  // address only steers the final selection.
  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    localparam bit OUT_BOT = (i < 2);
    localparam bit OUT_TOP = (i >= NGRP - 2);
    assign outer_vec[i] = top_boot ? OUT_TOP : OUT_BOT;
    always_comb begin
      if (wp == LVL_HV)
        eff_vec[i] = 1'b0;
      else if (wp == LVL_LOW && outer_vec[i])
        eff_vec[i] = 1'b1;
      else if (rl == LVL_HV)
        eff_vec[i] = 1'b0;
      else
        eff_vec[i] = stored[i];
    end
  end

  assign eff_prot   = eff_vec[grp];
  assign stored_bit = stored[grp];
  assign outer      = outer_vec[grp];

endmodule

// File: rtl/sect_prot_resolver.sv
module sect_prot_resolver
  import wpr_pkg::*;
#(
  parameter  int ADDR_W  = 21,
  parameter  int LARGE_W = 15,
  parameter  int BOOT_W  = 12,
  parameter  int GRP_SZ  = 4,
  localparam int NGRP    = grp_count(ADDR_W, LARGE_W, BOOT_W, GRP_SZ),
  localparam int GW      = $clog2(NGRP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              top_boot_i,
  input  logic [NGRP-1:0]   grp_prot_i,
  input  logic [1:0]        wp_lvl_i,
  input  logic [1:0]        rst_lvl_i,
  input  logic              req_i,
  output logic [GW-1:0]     grp_o,
  output logic [7:0]        prot_code_o,
  output logic              permit_o,
  output logic              go_o,
  output logic              reject_o,
  output logic              bypass_o
);

  lvl_e          wp_e, rl_e;
  logic [GW-1:0] grp_c;
  logic          eff_c, stored_c, outer_c, up_c;
  logic          unused_lo;

  assign wp_e      = lvl_e'(wp_lvl_i);
  assign rl_e      = lvl_e'(rst_lvl_i);
  assign unused_lo = ^addr_i[BOOT_W-1:0];
  assign up_c      = (rl_e != LVL_LOW);

  wpr_group_map #(
    .ADDR_W(ADDR_W), .LARGE_W(LARGE_W), .BOOT_W(BOOT_W),
    .GRP_SZ(GRP_SZ), .NGRP(NGRP), .GW(GW)
  ) u_map (
    .hi_addr (addr_i[ADDR_W-1:BOOT_W]),
    .top_boot(top_boot_i),
    .grp     (grp_c)
  );

  wpr_prot_eval #(.NGRP(NGRP), .GW(GW)) u_eval (
    .grp       (grp_c),
    .top_boot  (top_boot_i),
    .stored    (grp_prot_i),
    .wp        (wp_e),
    .rl        (rl_e),
    .eff_prot  (eff_c),
    .stored_bit(stored_c),
    .outer     (outer_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_o       <= '0;
      prot_code_o <= '0;
      permit_o    <= 1'b0;
      go_o        <= 1'b0;
      reject_o    <= 1'b0;
      bypass_o    <= 1'b0;
    end else begin
      grp_o       <= grp_c;
      prot_code_o <= {7'd0, stored_c};
      permit_o    <= up_c & ~eff_c;
      go_o        <= req_i & up_c & ~eff_c;
      reject_o    <= req_i & up_c & eff_c;
      bypass_o    <= (wp_e == LVL_HV);
    end
  end

  // R9: start and reject never coincide
  a_r9_excl: assert property (@(posedge clk) disable iff (rst)
    !(go_o && reject_o));

  // R9: no request, no pulse
  a_r9_no_req: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> (!go_o && !reject_o));

  // R9: a start pulse only where the address is writable
  a_r9_go_permit: assert property (@(posedge clk) disable iff (rst)
    go_o |-> permit_o);

  // R7: accelerate level opens every group and forces bypass
  a_r7_accel: assert property (@(posedge clk) disable iff (rst)
    (wp_lvl_i == 2'd2 && rst_lvl_i != 2'd0) |=> (permit_o && bypass_o));

  // R5: outermost boot groups stay locked under a low write-protect level
  a_r5_outer_low: assert property (@(posedge clk) disable iff (rst)
    (wp_lvl_i == 2'd0 && outer_c) |=> !permit_o);

endmodule

// File: tb/sim_sect_prot_resolver.sv
module sim_sect_prot_resolver;

  localparam int AW   = 21;
  localparam int NG   = 25;
  localparam int BOOT = 4096;
  localparam int BIG  = 32768;
  localparam int SPAN = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          top = 1'b0;
  logic [NG-1:0] prot = '0;
  logic [1:0]    wp = 2'd1;
  logic [1:0]    rl = 2'd1;
  logic          req = 1'b0;

  logic [4:0] grp_o;
  logic [7:0] code_o;
  logic       permit_o, go_o, reject_o, bypass_o;

  int nchk = 0;
  int nerr = 0;
  bit have_exp = 0;
  bit finished = 0;

  int    e_grp, e_code, e_permit, e_go, e_rej, e_byp;
  string t_grp, t_perm;
  bit    e_rst;

  always #10 clk = ~clk;

  sect_prot_resolver u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .top_boot_i(top),
    .grp_prot_i(prot), .wp_lvl_i(wp), .rst_lvl_i(rl), .req_i(req),
    .grp_o(grp_o), .prot_code_o(code_o), .permit_o(permit_o),
    .go_o(go_o), .reject_o(reject_o), .bypass_o(bypass_o)
  );

  function automatic int bot_group(int a);
    int s = a / BIG;
    if (a < BIG) return a / BOOT;
    if (s == SPAN / BIG - 1) return NG - 1;
    return 8 + s / 4;
  endfunction

  function automatic int ref_group(int a, bit tb);
    if (tb) return (NG - 1) - bot_group((SPAN - 1) - a);
    return bot_group(a);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s (R10 one-stage timing): actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare the previous edge's results, then apply new inputs and model them.
  task automatic cyc(int a, bit tb, logic [NG-1:0] p, int w, int r, bit q, bit rs);
    int  g;
    bit  outer, eff;
    @(negedge clk);
    if (have_exp) begin
      chk(e_rst ? "R1 grp" : t_grp, grp_o, e_grp);
      chk(e_rst ? "R1 verify" : "R4 verify", code_o, e_code);
      chk(e_rst ? "R1 permit" : t_perm, permit_o, e_permit);
      chk(e_rst ? "R1 go" : "R9 go", go_o, e_go);
      chk(e_rst ? "R1 reject" : "R9 reject", reject_o, e_rej);
      chk(e_rst ? "R1 bypass" : "R7 bypass", bypass_o, e_byp);
    end
    addr = a[AW-1:0]; top = tb; prot = p; wp = w[1:0]; rl = r[1:0];
    req = q; rst = rs;
    g     = ref_group(a, tb);
    outer = tb ? (g >= NG - 2) : (g < 2);
    if (w == 2) eff = 0;
    else if (w == 0 && outer) eff = 1;
    else if (r == 2) eff = 0;
    else eff = p[g];
    t_grp = tb ? "R3 grp" : "R2 grp";
    if (w == 2) t_perm = "R7 permit";
    else if (w == 0 && outer) t_perm = "R5 permit";
    else if (r == 0) t_perm = "R9 permit";
    else if (r == 2) t_perm = "R8 permit";
    else t_perm = "R6 permit";
    e_rst = rs;
    if (rs) begin
      e_grp = 0; e_code = 0; e_permit = 0; e_go = 0; e_rej = 0; e_byp = 0;
    end else begin
      e_grp    = g;
      e_code   = p[g] ? 1 : 0;
      e_permit = (r != 0 && !eff) ? 1 : 0;
      e_go     = (q && r != 0 && !eff) ? 1 : 0;
      e_rej    = (q && r != 0 && eff) ? 1 : 0;
      e_byp    = (w == 2) ? 1 : 0;
    end
    have_exp = 1;
  endtask

  task automatic sweep(bit tb, logic [NG-1:0] p, int w, int r);
    for (int k = 0; k < 8; k++)
      cyc(k * BOOT + ($urandom() % BOOT), tb, p, w, r, k[0], 0);
    for (int k = 0; k < SPAN / BIG; k++)
      cyc(k * BIG + ($urandom() % BIG), tb, p, w, r, ~k[0], 0);
    for (int k = 0; k < 8; k++)
      cyc(SPAN - BIG + k * BOOT + ($urandom() % BOOT), tb, p, w, r, 1, 0);
  endtask

  initial begin
    logic [NG-1:0] pat;
    // R1: reset dominates a request at the accelerate level
    cyc(0, 0, '1, 2, 1, 1, 1);
    cyc(SPAN - 1, 1, '1, 2, 2, 1, 1);
    cyc(SPAN - 1, 1, '1, 2, 2, 1, 1);
    // R2, R3, R4, R6: full walks in both orientations with stored patterns
    pat = 25'h0A5_3C96;
    sweep(0, pat, 1, 1);
    sweep(0, ~pat, 3, 3);
    sweep(1, pat, 1, 1);
    sweep(1, ~pat, 1, 3);
    sweep(0, '1, 1, 1);
    sweep(1, '0, 1, 1);
    // R5: low write-protect locks outer groups even with unprotect voltage
    cyc(BOOT + 5, 0, '0, 0, 2, 1, 0);
    cyc(3, 0, '0, 0, 1, 1, 0);
    cyc(SPAN - 1, 1, '0, 0, 2, 1, 0);
    cyc(SPAN - BOOT - 1, 1, '0, 0, 1, 1, 0);
    cyc(2 * BOOT, 0, '0, 0, 1, 1, 0);
    // R8: temporary unprotect, then restoration at the same address
    cyc(5 * BIG, 0, '1, 1, 2, 1, 0);
    cyc(5 * BIG, 0, '1, 1, 1, 1, 0);
    cyc(5 * BIG, 0, '1, 1, 2, 1, 0);
    cyc(5 * BIG, 0, '1, 1, 1, 0, 0);
    cyc(0, 0, '1, 1, 2, 1, 0);
    cyc(0, 0, '1, 1, 1, 1, 0);
    cyc(7 * BOOT, 1, '1, 0, 2, 1, 0);
    // R7: accelerate opens outer groups too, then falls back
    cyc(0, 0, '1, 2, 1, 1, 0);
    cyc(SPAN - 1, 1, '1, 2, 1, 1, 0);
    cyc(SPAN - 1, 1, '1, 1, 1, 1, 0);
    // R9: reset pin low suppresses both pulses
    cyc(9 * BIG, 0, '0, 1, 0, 1, 0);
    cyc(9 * BIG, 0, '1, 2, 0, 1, 0);
    cyc(9 * BIG, 0, '1, 1, 0, 1, 0);
    // Random crossing of all level pairs, stored patterns and orientations
    for (int n = 0; n < 3000; n++)
      cyc($urandom() % SPAN, n[5], NG'($urandom()), n % 4, (n / 4) % 4,
          $urandom() % 2 == 0, 0);
    // mid-run reset, R1
    cyc(BIG, 0, '1, 2, 1, 1, 1);
    cyc(BIG, 0, '0, 1, 1, 1, 0);
    cyc(BIG, 0, '0, 1, 1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL R10 watchdog: actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule